// File: doc/BRIEF.md
# SD/MMC Command Line Engine

This block runs the command side of an SD or MMC card link. It makes the card clock from the system clock through a programmable divider. On a start strobe it sends a 48-bit command frame on the bidirectional CMD line and computes the CRC7 of that frame as the bits go out. It then releases the line and waits for the card. If a response is expected, the engine captures a 48-bit or 136-bit reply, checks the reply's CRC7, and reports done together with a CRC-error or timeout flag.

Firmware chooses one of several card clock rates: a slow rate for the identification phase and faster rates for data transfer. A manual mode lets firmware take over the CMD line one bit at a time. In that mode firmware sets the driver enable and the output level directly, and it can read the last level sampled from the line.

Top module: `sdcmd_engine`

## Requirements
- R1: A command is sent MSB first as: 0, 1, the 6-bit index, the 32-bit argument, a CRC7 and a closing 1. The CRC7 uses the polynomial x^7+x^3+1 over the first 40 bits. Each bit changes only in the system cycle where sd_clk falls. For example, index 0 with argument 0 gives the frame 0x400000000095.
- R2: cmd_oe is high for exactly 48 card clock rising edges per command. It falls at the next falling edge after the closing bit and is low whenever done is high.
- R3: rsp_type 01 selects a short reply. After a start bit (0) is sampled, 48 bits are shifted into rsp_bits[47:0] and the upper bits read zero. The CRC7 is computed over rsp_bits[47:8] and compared with rsp_bits[7:1]. crc_err is raised if they differ.
- R4: rsp_type 1x selects a long reply. 136 bits are shifted into rsp_bits[135:0], and the CRC7 is computed only over rsp_bits[127:8] and compared with rsp_bits[7:1].
- R5: If no start bit is sampled within 64 rising card clock edges after release, timeout is raised with done, rsp_bits stays zero and crc_err stays low. A start bit on the 64th edge is still accepted.
- R6: With rsp_type 00, done rises in the same cycle that cmd_oe falls, and no reply is awaited.
- R7: rate_sel sets the half period of sd_clk to ceil(CLK_HZ/(2f)) system cycles. The codes are: 0, 6 and 7 give 375 kHz; 1 gives 6 MHz; 2 gives 15 MHz; 3 gives 20 MHz; 4 gives 24 MHz; 5 gives 48 MHz. The card clock runs continuously.
- R8: While man_en is high and the engine is idle, cmd_oe and cmd_o follow man_oe and man_out one cycle later, and start is ignored.
- R9: man_in takes the level of cmd_i at every rising edge of sd_clk.
- R10: done is a one-cycle pulse. busy is high from the cycle after an accepted start until done. crc_err and timeout hold their value until the next accepted start clears them.
- R11: After reset, sd_clk, cmd_oe, busy, done, crc_err and timeout are low, and rsp_bits is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_sel | input | 3 | Card clock rate code |
| start | input | 1 | Begin a command (one cycle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_type | input | 2 | 00 none, 01 short, 1x long |
| man_en | input | 1 | Manual CMD line control |
| man_oe | input | 1 | Manual driver enable |
| man_out | input | 1 | Manual output level |
| cmd_i | input | 1 | Level seen on the CMD line |
| sd_clk | output | 1 | Card clock |
| cmd_o | output | 1 | CMD output level |
| cmd_oe | output | 1 | CMD driver enable |
| man_in | output | 1 | CMD level at last rising card clock edge |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished (pulse) |
| crc_err | output | 1 | Reply CRC7 mismatch |
| timeout | output | 1 | No reply start bit seen |
| rsp_bits | output | 136 | Captured reply, last bit in bit 0 |

## Verification
The assertions take for granted that cmd_i changes only near falling card clock edges, so it is stable around each rising edge where the engine samples it. They also assume start is pulsed only while the engine is idle, and that rate_sel and man_en change only between transactions. The stimulus keeps to these rules. The card model in the bench drives every reply bit right after a falling edge of sd_clk. Each command is issued only after the previous result has left the scoreboard. Rate and manual-mode changes are made only while busy is low.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    localparam int CMD_HEAD_W   = 40;   // start, direction, index, argument
    localparam int CMD_FRAME_W  = 48;
    localparam int CRC_W        = 7;
    localparam int RSP_SHORT_W  = 48;
    localparam int RSP_LONG_W   = 136;
    localparam int LONG_CRC_LO  = 8;    // first protected bit position
    localparam int LONG_CRC_HI  = 128;  // one past last protected bit
    localparam int TMO_CLKS     = 64;
    localparam int BITN_W       = $clog2(RSP_LONG_W + 1);
    localparam int WCNT_W       = $clog2(TMO_CLKS + 1);
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_LISTEN,
        ST_RECV
    } seq_st_e;

    typedef struct packed {
        seq_st_e                 st;
        logic [BITN_W-1:0]       bitn;
        logic [CMD_HEAD_W-1:0]   sh;
        logic [CRC_W-1:0]        crc;
        logic [RSP_LONG_W-1:0]   rx;
        logic [WCNT_W-1:0]       wcnt;
        logic                    rlong;
        logic                    rnone;
        logic                    oe;
        logic                    dout;
        logic                    done;
        logic                    cerr;
        logic                    tmo;
        logic                    mbit;
    } seq_t;
endpackage

// File: rtl/sdcmd_clkdiv.sv
module sdcmd_clkdiv #(
    parameter int CLK_HZ  = 200_000_000,
    parameter int ID_HZ   = 375_000,
    parameter int XF1_HZ  = 6_000_000,
    parameter int XF2_HZ  = 15_000_000,
    parameter int XF3_HZ  = 20_000_000,
    parameter int XF4_HZ  = 24_000_000,
    parameter int HS_HZ   = 48_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rate_sel,
    output logic       sd_clk,
    output logic       rise_tick,
    output logic       fall_tick
);
    function automatic int half_of(input int f);
        int h;
        h = (CLK_HZ + 2 * f - 1) / (2 * f);
        return (h < 1) ? 1 : h;
    endfunction

    localparam int HALF_ID = half_of(ID_HZ);
    localparam int CW      = $clog2(HALF_ID + 1);

    localparam logic [CW-1:0] LIM_ID = CW'(HALF_ID);
    localparam logic [CW-1:0] LIM_1  = CW'(half_of(XF1_HZ));
    localparam logic [CW-1:0] LIM_2  = CW'(half_of(XF2_HZ));
    localparam logic [CW-1:0] LIM_3  = CW'(half_of(XF3_HZ));
    localparam logic [CW-1:0] LIM_4  = CW'(half_of(XF4_HZ));
    localparam logic [CW-1:0] LIM_HS = CW'(half_of(HS_HZ));

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          clk;
    } div_t;

    div_t d, q;
    logic [CW-1:0] lim;
    logic          tick;

    always_comb begin
        case (rate_sel)
            3'd1:    lim = LIM_1;
            3'd2:    lim = LIM_2;
            3'd3:    lim = LIM_3;
            3'd4:    lim = LIM_4;
            3'd5:    lim = LIM_HS;
            default: lim = LIM_ID;
        endcase
        tick  = (q.cnt >= lim - 1'b1);
        d     = q;
        if (tick) begin
            d.cnt = '0;
            d.clk = ~q.clk;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sd_clk    = q.clk;
    assign rise_tick = tick & ~q.clk;
    assign fall_tick = tick &  q.clk;
endmodule

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
    import sdcmd_pkg::*;
(
    input  logic [CRC_W-1:0] crc_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o
);
    logic fb;
    assign fb = crc_i[CRC_W-1] ^ bit_i;

    for (genvar i = 0; i < CRC_W; i++) begin : g_tap
        if (i == 0) begin : g_lsb
            assign crc_o[i] = CRC_POLY[i] & fb;
        end else begin : g_up
            assign crc_o[i] = crc_i[i-1] ^ (CRC_POLY[i] & fb);
        end
    end
endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
    import sdcmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [5:0]            cmd_idx,
    input  logic [31:0]           cmd_arg,
    input  logic [1:0]            rsp_type,
    input  logic                  man_en,
    input  logic                  man_oe,
    input  logic                  man_out,
    input  logic                  cmd_i,
    input  logic                  rise_tick,
    input  logic                  fall_tick,
    input  logic [CRC_W-1:0]      crc_nx,
    output logic [CRC_W-1:0]      crc_cur,
    output logic                  crc_bit,
    output logic                  cmd_o,
    output logic                  cmd_oe,
    output logic                  man_in,
    output logic                  busy,
    output logic                  done,
    output logic                  crc_err,
    output logic                  timeout,
    output logic [RSP_LONG_W-1:0] rsp_bits
);
    localparam logic [BITN_W-1:0] B_HEAD  = BITN_W'(CMD_HEAD_W);
    localparam logic [BITN_W-1:0] B_ENDB  = BITN_W'(CMD_FRAME_W - 1);
    localparam logic [BITN_W-1:0] B_SLAST = BITN_W'(RSP_SHORT_W - 1);
    localparam logic [BITN_W-1:0] B_LLAST = BITN_W'(RSP_LONG_W - 1);
    localparam logic [BITN_W-1:0] B_LLO   = BITN_W'(LONG_CRC_LO);
    localparam logic [BITN_W-1:0] B_LHI   = BITN_W'(LONG_CRC_HI);
    localparam logic [WCNT_W-1:0] W_LAST  = WCNT_W'(TMO_CLKS - 1);

    seq_t d, q;
    logic in_crc;
    logic last_bit;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (rise_tick) d.mbit = cmd_i;

        in_crc   = q.rlong ? (q.bitn >= B_LLO && q.bitn < B_LHI)
                           : (q.bitn < B_HEAD);
        last_bit = q.rlong ? (q.bitn == B_LLAST) : (q.bitn == B_SLAST);

        case (q.st)
            ST_IDLE: begin
                if (man_en) begin
                    d.oe   = man_oe;
                    d.dout = man_out;
                end else begin
                    d.oe = 1'b0;
                    if (start) begin
                        d.st    = ST_SEND;
                        d.bitn  = '0;
                        d.crc   = '0;
                        d.sh    = {2'b01, cmd_idx, cmd_arg};
                        d.rlong = rsp_type[1];
                        d.rnone = (rsp_type == 2'b00);
                        d.rx    = '0;
                        d.cerr  = 1'b0;
                        d.tmo   = 1'b0;
                    end
                end
            end
            ST_SEND: begin
                if (fall_tick) begin
                    d.bitn = q.bitn + 1'b1;
                    if (q.bitn < B_HEAD) begin
                        d.oe   = 1'b1;
                        d.dout = q.sh[CMD_HEAD_W-1];
                        d.sh   = {q.sh[CMD_HEAD_W-2:0], 1'b0};
                        d.crc  = crc_nx;
                    end else if (q.bitn < B_ENDB) begin
                        d.dout = q.crc[CRC_W-1];
                        d.crc  = {q.crc[CRC_W-2:0], 1'b0};
                    end else if (q.bitn == B_ENDB) begin
                        d.dout = 1'b1;
                    end else begin
                        d.oe   = 1'b0;
                        d.bitn = '0;
                        d.wcnt = '0;
                        if (q.rnone) begin
                            d.done = 1'b1;
                            d.st   = ST_IDLE;
                        end else begin
                            d.st = ST_LISTEN;
                        end
                    end
                end
            end
            ST_LISTEN: begin
                if (rise_tick) begin
                    if (!cmd_i) begin
                        d.st   = ST_RECV;
                        d.bitn = BITN_W'(1);
                        d.rx   = {q.rx[RSP_LONG_W-2:0], 1'b0};
                        d.crc  = '0;
                    end else if (q.wcnt == W_LAST) begin
                        d.tmo  = 1'b1;
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.wcnt = q.wcnt + 1'b1;
                    end
                end
            end
            default: begin
                if (rise_tick) begin
                    d.rx   = {q.rx[RSP_LONG_W-2:0], cmd_i};
                    d.bitn = q.bitn + 1'b1;
                    if (in_crc) d.crc = crc_nx;
                    if (last_bit) begin
                        d.cerr = (q.rx[CRC_W-1:0] != q.crc);
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.dout <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign crc_cur  = q.crc;
    assign crc_bit  = (q.st == ST_SEND) ? q.sh[CMD_HEAD_W-1] : cmd_i;
    assign cmd_o    = q.dout;
    assign cmd_oe   = q.oe;
    assign man_in   = q.mbit;
    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign crc_err  = q.cerr;
    assign timeout  = q.tmo;
    assign rsp_bits = q.rx;
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int CLK_HZ = 200_000_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            rate_sel,
    input  logic                  start,
    input  logic [5:0]            cmd_idx,
    input  logic [31:0]           cmd_arg,
    input  logic [1:0]            rsp_type,
    input  logic                  man_en,
    input  logic                  man_oe,
    input  logic                  man_out,
    input  logic                  cmd_i,
    output logic                  sd_clk,
    output logic                  cmd_o,
    output logic                  cmd_oe,
    output logic                  man_in,
    output logic                  busy,
    output logic                  done,
    output logic                  crc_err,
    output logic                  timeout,
    output logic [RSP_LONG_W-1:0] rsp_bits
);
    logic             rise_tick, fall_tick;
    logic [CRC_W-1:0] crc_cur, crc_nx;
    logic             crc_bit;

    sdcmd_clkdiv #(.CLK_HZ(CLK_HZ)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_sel  (rate_sel),
        .sd_clk    (sd_clk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    sdcmd_crc7 u_crc (
        .crc_i (crc_cur),
        .bit_i (crc_bit),
        .crc_o (crc_nx)
    );

    sdcmd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_idx   (cmd_idx),
        .cmd_arg   (cmd_arg),
        .rsp_type  (rsp_type),
        .man_en    (man_en),
        .man_oe    (man_oe),
        .man_out   (man_out),
        .cmd_i     (cmd_i),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .crc_nx    (crc_nx),
        .crc_cur   (crc_cur),
        .crc_bit   (crc_bit),
        .cmd_o     (cmd_o),
        .cmd_oe    (cmd_oe),
        .man_in    (man_in),
        .busy      (busy),
        .done      (done),
        .crc_err   (crc_err),
        .timeout   (timeout),
        .rsp_bits  (rsp_bits)
    );
endmodule

// File: rtl/sdcmd_chk.sv
module sdcmd_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic man_en,
    input logic man_oe,
    input logic sd_clk,
    input logic cmd_o,
    input logic cmd_oe,
    input logic busy,
    input logic done,
    input logic crc_err,
    input logic timeout
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                           // R10
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !man_en) |=> busy);                     // R10
    AST_TX_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$stable(cmd_o)) |-> $fell(sd_clk));              // R1
    AST_RELEASE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_oe);                                         // R2
    AST_TMO_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> done);                                  // R5
    AST_CERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> done);                                  // R3
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(timeout && crc_err));                                    // R5
    AST_MAN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (man_en && !busy) |=> (cmd_oe == $past(man_oe)));          // R8
endmodule

bind sdcmd_engine sdcmd_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .man_en  (man_en),
    .man_oe  (man_oe),
    .sd_clk  (sd_clk),
    .cmd_o   (cmd_o),
    .cmd_oe  (cmd_oe),
    .busy    (busy),
    .done    (done),
    .crc_err (crc_err),
    .timeout (timeout)
);

// File: tb/sim_sdcmd_engine.sv
`timescale 1ns/1ps
module sim_sdcmd_engine;
    localparam int CLK_HZ = 200_000_000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   rate_sel = 3'd5;
    logic         start = 1'b0;
    logic [5:0]   cmd_idx = '0;
    logic [31:0]  cmd_arg = '0;
    logic [1:0]   rsp_type = '0;
    logic         man_en = 1'b0, man_oe = 1'b0, man_out = 1'b1;
    logic         cmd_i = 1'b1;
    logic         sd_clk, cmd_o, cmd_oe, man_in, busy, done, crc_err, timeout;
    logic [135:0] rsp_bits;

    always #2.5 clk = ~clk;

    sdcmd_engine #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .start(start),
        .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .rsp_type(rsp_type),
        .man_en(man_en), .man_oe(man_oe), .man_out(man_out), .cmd_i(cmd_i),
        .sd_clk(sd_clk), .cmd_o(cmd_o), .cmd_oe(cmd_oe), .man_in(man_in),
        .busy(busy), .done(done), .crc_err(crc_err), .timeout(timeout),
        .rsp_bits(rsp_bits)
    );

    typedef struct {
        logic [135:0] rsp;
        logic         cerr;
        logic         tmo;
        logic [47:0]  frm;
        logic         none;
        string        tag;
    } exp_t;

    exp_t        exp_q[$];
    int          n_chk = 0, n_fail = 0;
    logic [47:0] frm_cap = '0;
    int          oe_cnt = 0;
    logic        oe_prev = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [135:0] act, input logic [135:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [135:0] v, input int hi, input int n);
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = 0; i < n; i++) begin
            fb = c[6] ^ v[hi-i];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic int ref_half(input int f);
        return (CLK_HZ + 2 * f - 1) / (2 * f);
    endfunction

    // frame capture at every rising card clock edge while the engine drives
    always @(posedge sd_clk) begin
        if (cmd_oe === 1'b1) begin
            frm_cap = {frm_cap[46:0], cmd_o};
            oe_cnt  = oe_cnt + 1;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8/R10 unexpected done", 136'(done), 136'(0));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_bits === e.rsp, {e.tag, " rsp_bits"}, rsp_bits, e.rsp);
                chk(crc_err === e.cerr, {e.tag, " crc_err"}, 136'(crc_err), 136'(e.cerr));
                chk(timeout === e.tmo, {e.tag, " timeout R5"}, 136'(timeout), 136'(e.tmo));
                chk(frm_cap === e.frm, {e.tag, " frame R1"}, 136'(frm_cap), 136'(e.frm));
                chk(oe_cnt == 48 && cmd_oe === 1'b0, {e.tag, " R2 drive length"}, 136'(oe_cnt), 136'(48));
                if (e.none)
                    chk(oe_prev === 1'b1, {e.tag, " R6 done with release"}, 136'(oe_prev), 136'(1));
            end
        end
        oe_prev = cmd_oe;
    end

    // driver: mode 0 good reply, 1 corrupted CRC, 2 silent card
    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rt,
                           input int mode, input int dly, input string tag);
        exp_t         e;
        logic [47:0]  frm;
        logic [135:0] rsp;
        int           nbits;
        frm = {1'b0, 1'b1, idx, arg, 7'b0, 1'b1};
        frm[7:1] = ref_crc({88'b0, frm}, 47, 40);
        rsp = '0;
        nbits = 0;
        if (rt == 2'b01) begin
            rsp[47:0] = {2'b00, idx, ~arg, 7'b0, 1'b1};
            rsp[7:1]  = ref_crc(rsp, 47, 40);
            nbits = 48;
        end else if (rt[1]) begin
            rsp = {2'b00, 6'h3F, arg, ~arg, arg ^ 32'h5A5A_C3C3, 24'hA5_0F_96, 7'b0, 1'b1};
            rsp[7:1] = ref_crc(rsp, 127, 120);
            nbits = 136;
        end
        if (mode == 1) rsp[1] = ~rsp[1];
        e.frm  = frm;
        e.none = (rt == 2'b00);
        e.tag  = tag;
        e.cerr = (mode == 1);
        e.tmo  = (mode == 2) && (rt != 2'b00);
        e.rsp  = (mode == 2 || rt == 2'b00) ? '0 : rsp;
        exp_q.push_back(e);
        @(negedge clk);
        frm_cap = '0;
        oe_cnt  = 0;
        cmd_idx = idx; cmd_arg = arg; rsp_type = rt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, {tag, " R10 busy after start"}, 136'(busy), 136'(1));
        chk(crc_err === 1'b0 && timeout === 1'b0, {tag, " R10 flags cleared"},
            136'({crc_err, timeout}), 136'(0));
        wait (oe_cnt == 48);
        if (nbits != 0 && mode != 2) begin
            repeat (dly - 1) @(negedge sd_clk);
            for (int i = nbits - 1; i >= 0; i--) begin
                @(negedge sd_clk);
                cmd_i = rsp[i];
            end
            @(negedge sd_clk);
            cmd_i = 1'b1;
        end
        wait (exp_q.size() == 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic measure(input logic [2:0] code, input int f, input string tag);
        realtime t0, t1;
        int      cyc;
        @(negedge clk);
        rate_sel = code;
        repeat (3) @(posedge sd_clk);
        t0 = $realtime;
        @(posedge sd_clk);
        t1 = $realtime;
        cyc = int'((t1 - t0) / 5.0);
        chk(cyc == 2 * ref_half(f), tag, 136'(cyc), 136'(2 * ref_half(f)));
    endtask

    initial begin : watchdog
        repeat (180_000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(sd_clk === 1'b0 && cmd_oe === 1'b0, "R11 clock/oe in reset", 136'({sd_clk, cmd_oe}), 136'(0));
        chk({busy, done, crc_err, timeout} === 4'b0, "R11 status in reset",
            136'({busy, done, crc_err, timeout}), 136'(0));
        chk(rsp_bits === '0, "R11 rsp_bits in reset", rsp_bits, 136'(0));
        rst_n = 1'b1;

        // R7 rates
        measure(3'd0, 375_000, "R7 ident rate");
        measure(3'd1, 6_000_000, "R7 6 MHz");
        measure(3'd2, 15_000_000, "R7 15 MHz");
        measure(3'd3, 20_000_000, "R7 20 MHz");
        measure(3'd4, 24_000_000, "R7 24 MHz");
        measure(3'd5, 48_000_000, "R7 48 MHz");
        measure(3'd7, 375_000, "R7 spare code");
        @(negedge clk);
        rate_sel = 3'd5;
        repeat (20) @(negedge clk);

        // R1 known frame, no reply (R6)
        run_cmd(6'd0, 32'h0, 2'b00, 0, 1, "R6 no-reply cmd");
        chk(frm_cap === 48'h40_0000_0000_95, "R1 known frame", 136'(frm_cap), 136'(48'h400000000095));

        // R3 short replies
        run_cmd(6'd8, 32'h0000_01AA, 2'b01, 0, 2, "R3 short good");
        run_cmd(6'd17, 32'hDEAD_BEEF, 2'b01, 1, 3, "R3 short bad crc");
        repeat (20) @(negedge clk);
        chk(crc_err === 1'b1, "R10 crc_err held", 136'(crc_err), 136'(1));

        // R4 long replies
        run_cmd(6'd2, 32'h1234_5678, 2'b10, 0, 4, "R4 long good");
        run_cmd(6'd9, 32'hCAFE_0001, 2'b11, 1, 1, "R4 long bad crc");

        // R5 timeout and boundary
        run_cmd(6'd55, 32'h0, 2'b01, 2, 1, "R5 silent card");
        repeat (20) @(negedge clk);
        chk(timeout === 1'b1, "R10 timeout held", 136'(timeout), 136'(1));
        run_cmd(6'd13, 32'h0001_0000, 2'b01, 0, 64, "R5 start on last edge");

        // slower rate transaction
        @(negedge clk);
        rate_sel = 3'd1;
        repeat (40) @(negedge clk);
        run_cmd(6'd3, 32'hFFFF_0000, 2'b01, 0, 5, "R7 short at 6 MHz");
        @(negedge clk);
        rate_sel = 3'd5;
        repeat (40) @(negedge clk);

        // R8 manual drive
        man_en = 1'b1; man_oe = 1'b1; man_out = 1'b0;
        repeat (2) @(negedge clk);
        chk(cmd_oe === 1'b1 && cmd_o === 1'b0, "R8 manual drive low", 136'({cmd_oe, cmd_o}), 136'(2'b10));
        man_out = 1'b1;
        repeat (2) @(negedge clk);
        chk(cmd_o === 1'b1, "R8 manual drive high", 136'(cmd_o), 136'(1));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        chk(busy === 1'b0 && cmd_oe === 1'b1, "R8 start ignored", 136'({busy, cmd_oe}), 136'(2'b01));
        man_oe = 1'b0;
        repeat (2) @(negedge clk);
        chk(cmd_oe === 1'b0, "R8 manual release", 136'(cmd_oe), 136'(0));

        // R9 sampling
        cmd_i = 1'b0;
        @(posedge sd_clk);
        @(negedge clk);
        chk(man_in === 1'b0, "R9 sample low", 136'(man_in), 136'(0));
        cmd_i = 1'b1;
        @(posedge sd_clk);
        @(negedge clk);
        chk(man_in === 1'b1, "R9 sample high", 136'(man_in), 136'(1));
        man_en = 1'b0;
        repeat (10) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule